// File: doc/BRIEF.md
# MSI Interrupt File

This block is one interrupt file serving a single hart at a single privilege level. Devices deliver message-signalled interrupts by writing an identity number into a 4 KiB page. Each write sets the pending bit for that identity. An enable bit array sits beside the pending array. The file drives the hart's external-interrupt line whenever some identity is both pending and enabled. The machine-level file feeds interrupt cause 11 and the supervisor-level file feeds cause 9.

Software never addresses the two arrays directly. It first loads a select register to choose one 32-bit pending word or enable word. It then reads that word, or updates it through a data port that can write the whole word, set bits or clear bits. Software finds work by reading a top-identity register, which reports the lowest-numbered deliverable identity. Reading it with a swap of zero claims that identity and clears its pending bit. Software keeps claiming until the register reads zero.

The MSI port is a valid/ready stream. Ready is low during reset and high from the first clock edge after reset, and the file never applies back-pressure after that. A write is consumed in the cycle where valid and ready are both high. Control pins are plain levels and pulses.

Top module: `msi_ifile`

## Requirements
- R1: After reset all pending and enable bits are zero, `ext_irq` is low and `top_rdata` reads zero.
- R2: `msi_ready` is high from the first clock edge after reset. An accepted MSI with `msi_addr` equal to 0 and `msi_data` equal to N, where 1 <= N <= NUM_IDS, sets pending bit N at that clock edge.
- R3: An MSI is ignored and changes no bit if its data is 0, its data is above NUM_IDS, or its address is nonzero.
- R4: `top_rdata` holds the smallest identity that is both pending and enabled in bits 27:16, with all other bits zero. It reads zero when no identity is deliverable. A pending identity that is not enabled is never reported.
- R5: A `top_claim` pulse clears the pending bit of the identity that `top_rdata` shows in that cycle. From the next cycle on, `top_rdata` shows the next deliverable identity, or zero.
- R6: A select value of 0x80+k addresses pending word k and 0xC0+k addresses enable word k. Bit j of word k is identity 32k+j. Any other select value, or any k at or above the word count, reads zero and ignores updates.
- R7: `csr_data_op` encodes the update applied at the clock edge to the selected word: 0 does nothing, 1 writes the word, 2 sets the bits that are one in the write data, and 3 clears the bits that are one in the write data. `csr_data_rdata` shows the selected word before the update.
- R8: Identity 0, and any identity above NUM_IDS, always reads zero in both arrays and cannot be set.
- R9: `ext_irq` is registered. After each clock edge it shows whether any identity was deliverable just before that edge. It therefore falls one cycle after the last deliverable identity is claimed or disabled.
- R10: When an MSI and a claim target the same identity in the same cycle, the MSI wins and the identity stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | MSI write valid |
| msi_ready | output | 1 | MSI write ready |
| msi_addr | input | 12 | Byte offset of the write inside the page |
| msi_data | input | 32 | Identity number carried by the write |
| csr_sel_we | input | 1 | Loads the select register |
| csr_sel_wdata | input | 8 | New select value |
| csr_data_op | input | 2 | Update applied to the selected word (R7) |
| csr_data_wdata | input | 32 | Data for the word update |
| csr_data_rdata | output | 32 | Selected word, read value |
| top_rdata | output | 32 | Top deliverable identity in bits 27:16 |
| top_claim | input | 1 | Swap-with-zero of the top register: claims the shown identity |
| ext_irq | output | 1 | External-interrupt request to the hart |

## Verification
A bad pending or enable bit can be seen at the ports in two ways. It shows on the same cycle on `csr_data_rdata` once the right word is selected. It also changes `top_rdata` combinationally as soon as the bit is both pending and enabled. A wrong priority choice or a claim of the wrong bit shows up as an out-of-order identity in the claim loop. A lost MSI shows up as a missing identity in that loop. Errors in the output register appear on `ext_irq` exactly one cycle after the array state that should have caused them.

// File: rtl/msi_ifile_pkg.sv
package msi_ifile_pkg;

  typedef enum logic [1:0] {
    DOP_NONE  = 2'd0,
    DOP_WRITE = 2'd1,
    DOP_SET   = 2'd2,
    DOP_CLEAR = 2'd3
  } dop_e;

  localparam logic [1:0] SEL_PEND_TAG = 2'b10;
  localparam logic [1:0] SEL_EN_TAG   = 2'b11;
  localparam int unsigned WORD_W      = 32;

  function automatic logic [WORD_W-1:0] apply_op(
    input logic [WORD_W-1:0] old_w,
    input dop_e              op,
    input logic [WORD_W-1:0] wd
  );
    case (op)
      DOP_WRITE: return wd;
      DOP_SET:   return old_w | wd;
      DOP_CLEAR: return old_w & ~wd;
      default:   return old_w;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] impl_mask(input int w, input int n_ids);
    logic [WORD_W-1:0] m;
    for (int j = 0; j < WORD_W; j++) begin
      m[j] = ((w * WORD_W + j) >= 1) && ((w * WORD_W + j) <= n_ids);
    end
    return m;
  endfunction

endpackage

// File: rtl/msi_ifile_store.sv
module msi_ifile_store
  import msi_ifile_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int NW      = 2,
  parameter int ID_W    = 6,
  parameter int WI_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_pend_hit,
  input  logic                 csr_en_hit,
  input  logic [WI_W-1:0]      csr_idx,
  input  dop_e                 csr_op,
  input  logic [WORD_W-1:0]    csr_wdata,
  input  logic                 msi_en,
  input  logic [ID_W-1:0]      msi_id,
  input  logic                 claim_en,
  input  logic [ID_W-1:0]      claim_id,
  output logic [NW*WORD_W-1:0] pend_vec,
  output logic [NW*WORD_W-1:0] en_vec
);

  localparam int WB_W = ID_W - 5;

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam logic [WORD_W-1:0] MASK = impl_mask(w, NUM_IDS);
    logic [WORD_W-1:0] pend_q, en_q, pend_d, en_d;
    logic              this_word;
    logic              claim_here, msi_here;

    assign this_word  = (csr_idx == WI_W'(w));
    assign claim_here = claim_en && (claim_id[ID_W-1:5] == WB_W'(w));
    assign msi_here   = msi_en && (msi_id[ID_W-1:5] == WB_W'(w));

    always_comb begin
      pend_d = pend_q;
      if (csr_pend_hit && this_word) pend_d = apply_op(pend_d, csr_op, csr_wdata);
      if (claim_here) pend_d[claim_id[4:0]] = 1'b0;
      if (msi_here)   pend_d[msi_id[4:0]]   = 1'b1;
      pend_d = pend_d & MASK;
    end

    always_comb begin
      en_d = en_q;
      if (csr_en_hit && this_word) en_d = apply_op(en_d, csr_op, csr_wdata);
      en_d = en_d & MASK;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= '0;
        en_q   <= '0;
      end else begin
        pend_q <= pend_d;
        en_q   <= en_d;
      end
    end

    assign pend_vec[w*WORD_W +: WORD_W] = pend_q;
    assign en_vec[w*WORD_W +: WORD_W]   = en_q;
  end

  p_msi_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> pend_vec[$past(msi_id)]);

  p_set_beats_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && claim_en && msi_id == claim_id) |=> pend_vec[$past(claim_id)]);

  p_enable_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en_hit |=> $stable(en_vec));

  p_id_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vec[0] && !en_vec[0]);

endmodule

// File: rtl/msi_ifile_prio.sv
module msi_ifile_prio #(
  parameter int NUM_IDS = 63,
  parameter int VW      = 64,
  parameter int ID_W    = 6
) (
  input  logic [VW-1:0]   deliver,
  output logic [ID_W-1:0] top_id
);

  always_comb begin
    top_id = '0;
    for (int i = NUM_IDS; i >= 1; i--) begin
      if (deliver[i]) top_id = ID_W'(i);
    end
  end

  always_comb begin
    if (top_id != '0) begin
      a_top_is_live_r4: assert (deliver[top_id]);
    end
  end

endmodule

// File: rtl/msi_ifile_csr.sv
module msi_ifile_csr
  import msi_ifile_pkg::*;
#(
  parameter int NW   = 2,
  parameter int WI_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_we,
  input  logic [7:0]           sel_wdata,
  input  logic [NW*WORD_W-1:0] pend_vec,
  input  logic [NW*WORD_W-1:0] en_vec,
  output logic                 pend_hit,
  output logic                 en_hit,
  output logic [WI_W-1:0]      word_idx,
  output logic [WORD_W-1:0]    rdata
);

  logic [7:0] sel_q;
  logic       in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  assign in_range = int'(sel_q[5:0]) < NW;
  assign word_idx = sel_q[WI_W-1:0];
  assign pend_hit = in_range && (sel_q[7:6] == SEL_PEND_TAG);
  assign en_hit   = in_range && (sel_q[7:6] == SEL_EN_TAG);

  always_comb begin
    rdata = '0;
    if (pend_hit)    rdata = pend_vec[int'(word_idx)*WORD_W +: WORD_W];
    else if (en_hit) rdata = en_vec[int'(word_idx)*WORD_W +: WORD_W];
  end

  p_one_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_hit && en_hit));

endmodule

// File: rtl/msi_ifile.sv
module msi_ifile
  import msi_ifile_pkg::*;
#(
  parameter int NUM_IDS = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msi_valid,
  output logic        msi_ready,
  input  logic [11:0] msi_addr,
  input  logic [31:0] msi_data,
  input  logic        csr_sel_we,
  input  logic [7:0]  csr_sel_wdata,
  input  logic [1:0]  csr_data_op,
  input  logic [31:0] csr_data_wdata,
  output logic [31:0] csr_data_rdata,
  output logic [31:0] top_rdata,
  input  logic        top_claim,
  output logic        ext_irq
);

  localparam int TOT  = NUM_IDS + 1;
  localparam int NW   = (TOT + WORD_W - 1) / WORD_W;
  localparam int VW   = NW * WORD_W;
  localparam int ID_W = $clog2(TOT);
  localparam int WI_W = (NW > 1) ? $clog2(NW) : 1;

  logic            rdy_q, ext_q;
  logic            msi_en, claim_en, any_del;
  logic [ID_W-1:0] top_id;
  logic [VW-1:0]   pend_vec, en_vec;
  logic            pend_hit, en_hit;
  logic [WI_W-1:0] word_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      ext_q <= any_del;
    end
  end

  assign msi_ready = rdy_q;
  assign ext_irq   = ext_q;
  assign msi_en    = msi_valid && rdy_q && (msi_addr == 12'd0) &&
                     (msi_data != 32'd0) && (msi_data <= 32'(NUM_IDS));
  assign claim_en  = top_claim && (top_id != '0);
  assign any_del   = |(pend_vec & en_vec);
  assign top_rdata = {4'd0, 12'(top_id), 16'd0};

  msi_ifile_csr #(.NW(NW), .WI_W(WI_W)) csr_i (
    .clk(clk), .rst_n(rst_n),
    .sel_we(csr_sel_we), .sel_wdata(csr_sel_wdata),
    .pend_vec(pend_vec), .en_vec(en_vec),
    .pend_hit(pend_hit), .en_hit(en_hit),
    .word_idx(word_idx), .rdata(csr_data_rdata)
  );

  msi_ifile_store #(.NUM_IDS(NUM_IDS), .NW(NW), .ID_W(ID_W), .WI_W(WI_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .csr_pend_hit(pend_hit), .csr_en_hit(en_hit), .csr_idx(word_idx),
    .csr_op(dop_e'(csr_data_op)), .csr_wdata(csr_data_wdata),
    .msi_en(msi_en), .msi_id(msi_data[ID_W-1:0]),
    .claim_en(claim_en), .claim_id(top_id),
    .pend_vec(pend_vec), .en_vec(en_vec)
  );

  msi_ifile_prio #(.NUM_IDS(NUM_IDS), .VW(VW), .ID_W(ID_W)) prio_i (
    .deliver(pend_vec & en_vec),
    .top_id(top_id)
  );

  p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (top_id == '0) == !any_del);

  p_ext_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_del |=> ext_irq);

  p_ext_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_del |=> !ext_irq);

  p_claim_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && !msi_en && !pend_hit) |=> !pend_vec[$past(top_id)]);

endmodule

// File: tb/msi_ifile_tb_top.sv
module msi_ifile_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [11:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        csr_sel_we = 1'b0;
  logic [7:0]  csr_sel_wdata = '0;
  logic [1:0]  csr_data_op = '0;
  logic [31:0] csr_data_wdata = '0;
  logic [31:0] csr_data_rdata;
  logic [31:0] top_rdata;
  logic        top_claim = 1'b0;
  logic        ext_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_ifile dut_i (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data),
    .csr_sel_we(csr_sel_we), .csr_sel_wdata(csr_sel_wdata),
    .csr_data_op(csr_data_op), .csr_data_wdata(csr_data_wdata),
    .csr_data_rdata(csr_data_rdata), .top_rdata(top_rdata),
    .top_claim(top_claim), .ext_irq(ext_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic msi(input logic [11:0] a, input logic [31:0] d);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    tick();
    msi_valid = 1'b0; msi_addr = '0; msi_data = '0;
  endtask

  task automatic sel(input logic [7:0] s);
    csr_sel_we = 1'b1; csr_sel_wdata = s;
    tick();
    csr_sel_we = 1'b0;
  endtask

  task automatic dop(input logic [7:0] s, input logic [1:0] op, input logic [31:0] wd);
    sel(s);
    csr_data_op = op; csr_data_wdata = wd;
    tick();
    csr_data_op = 2'd0; csr_data_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] s, input logic [31:0] exp);
    sel(s);
    check(req, csr_data_rdata, exp);
  endtask

  task automatic claim();
    top_claim = 1'b1;
    tick();
    top_claim = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    check("R1 ext", {31'd0, ext_irq}, 32'd0);
    check("R1 top", top_rdata, 32'd0);
    rst_n = 1'b1;
    tick();
    check("R2 ready", {31'd0, msi_ready}, 32'd1);
    rd_check("R1 pend0", 8'h80, 32'd0);
    rd_check("R1 en1", 8'hC1, 32'd0);
  endtask

  task automatic t_msi_pending();
    msi(12'd0, 32'd5);
    msi(12'd0, 32'd40);
    rd_check("R2 pend0", 8'h80, 32'h0000_0020);
    rd_check("R2 pend1", 8'h81, 32'h0000_0100);
    check("R4 not enabled top", top_rdata, 32'd0);
    tick();
    check("R4 not enabled ext", {31'd0, ext_irq}, 32'd0);
  endtask

  task automatic t_ignored();
    msi(12'd0, 32'd0);
    msi(12'd0, 32'd64);
    msi(12'h004, 32'd9);
    msi(12'd0, 32'hFFFF_FFFF);
    rd_check("R3 pend0", 8'h80, 32'h0000_0020);
    rd_check("R3 pend1", 8'h81, 32'h0000_0100);
  endtask

  task automatic t_enable_ops();
    dop(8'hC0, 2'd1, 32'h0000_0028);
    check("R7 write", csr_data_rdata, 32'h0000_0028);
    dop(8'hC0, 2'd2, 32'h0000_0200);
    check("R7 set", csr_data_rdata, 32'h0000_0228);
    dop(8'hC0, 2'd3, 32'h0000_0008);
    check("R7 clear", csr_data_rdata, 32'h0000_0220);
    dop(8'hC0, 2'd0, 32'hFFFF_FFFF);
    check("R7 none", csr_data_rdata, 32'h0000_0220);
    dop(8'hC1, 2'd2, 32'h0000_0100);
    check("R6 en word1", csr_data_rdata, 32'h0000_0100);
  endtask

  task automatic t_priority_claim();
    msi(12'd0, 32'd3);
    msi(12'd0, 32'd9);
    check("R4 lowest", top_rdata, 32'd5 << 16);
    check("R9 ext up", {31'd0, ext_irq}, 32'd1);
    claim();
    check("R5 next 9", top_rdata, 32'd9 << 16);
    claim();
    check("R5 next 40", top_rdata, 32'd40 << 16);
    claim();
    check("R5 empty", top_rdata, 32'd0);
    check("R9 ext lag", {31'd0, ext_irq}, 32'd1);
    tick();
    check("R9 ext fall", {31'd0, ext_irq}, 32'd0);
    rd_check("R5 pend0 left", 8'h80, 32'h0000_0008);
    rd_check("R5 pend1 left", 8'h81, 32'd0);
  endtask

  task automatic t_unimpl();
    dop(8'h80, 2'd1, 32'hFFFF_FFFF);
    check("R8 id0", csr_data_rdata, 32'hFFFF_FFFE);
    dop(8'h81, 2'd1, 32'hFFFF_FFFF);
    check("R8 word1 full", csr_data_rdata, 32'hFFFF_FFFF);
    dop(8'h80, 2'd1, 32'd0);
    dop(8'h81, 2'd1, 32'd0);
    check("R8 cleared", csr_data_rdata, 32'd0);
  endtask

  task automatic t_sel_outside();
    dop(8'hC2, 2'd2, 32'hFFFF_FFFF);
    check("R6 beyond words", csr_data_rdata, 32'd0);
    dop(8'h40, 2'd1, 32'hFFFF_FFFF);
    check("R6 other tag", csr_data_rdata, 32'd0);
    rd_check("R6 en0 kept", 8'hC0, 32'h0000_0220);
    rd_check("R6 en1 kept", 8'hC1, 32'h0000_0100);
    rd_check("R6 pend0 kept", 8'h80, 32'd0);
  endtask

  task automatic t_race();
    msi(12'd0, 32'd7);
    dop(8'hC0, 2'd2, 32'h0000_0080);
    check("R4 top 7", top_rdata, 32'd7 << 16);
    top_claim = 1'b1;
    msi(12'd0, 32'd7);
    top_claim = 1'b0;
    check("R10 still top", top_rdata, 32'd7 << 16);
    rd_check("R10 still pending", 8'h80, 32'h0000_0080);
    claim();
    check("R5 claimed 7", top_rdata, 32'd0);
    rd_check("R5 pend0 empty", 8'h80, 32'd0);
  endtask

  initial begin
    t_reset();
    t_msi_pending();
    t_ignored();
    t_enable_ops();
    t_priority_claim();
    t_unimpl();
    t_sel_outside();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule